// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This block forms the 32-bit byte address of a load or store from the operands that the register file and the decoder have already produced. These operands are a base value, an index value, a 2-bit scale code and a displacement. A 3-bit mode input picks how they are combined. The choices are the base alone, base plus displacement, the sum of two registers, base plus a scaled index, or base plus a scaled index plus a displacement. The displacement is taken either as a full 32-bit value or as a sign-extended 8-bit value, and a select input chooses between them for each access.

The address path is purely combinational. The address is valid in the same cycle that the operands are presented. An auto-update mode also forms base plus displacement as the access address. On the next clock edge it hands that same address back as a new base value, with a writeback strobe, so the register file can step a pointer through memory without a separate add. All arithmetic wraps modulo 2^32, and no flag is raised.

Top module: `eff_addr_gen`

## Requirements
- R1: With mode 3'd0 (register indirect), `addr` equals `base` and ignores `index`, `scale` and `disp`.
- R2: With mode 3'd1 (based), `addr` equals `base` plus the effective displacement. When `disp_wide`=1, the effective displacement is all 32 bits of `disp`.
- R3: When `disp_wide`=0, the effective displacement is `disp[7:0]` sign-extended to 32 bits, and `disp[31:8]` has no effect on `addr`.
- R4: With mode 3'd2 (indexed), `addr` equals `base` plus `index`. Both `scale` and `disp` are ignored.
- R5: With mode 3'd3 (scaled index), `addr` equals `base` plus `index` shifted left by `scale`, which multiplies the index by 1, 2, 4 or 8.
- R6: With mode 3'd4 (scaled index plus displacement), `addr` equals `base` plus the scaled index plus the effective displacement.
- R7: Every sum wraps modulo 2^32.
- R8: With mode 3'd5 (update), `addr` equals `base` plus the effective displacement. One clock edge later, `wb_en` is 1 and `wb_val` equals that address.
- R9: After a clock edge at which the mode was anything other than 3'd5, `wb_en` is 0 and `wb_val` keeps its previous value.
- R10: Modes 3'd6 and 3'd7 give `addr` = 0 and leave `wb_en` low.
- R11: While `rst_n` is low, `wb_en` and `wb_val` are 0.
- R12: Addresses count bytes. In mode 3'd3 with `scale`=2, consecutive index values give addresses 4 apart, and a word-aligned base stays word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the writeback register |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Addressing-mode select |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| scale | input | 2 | Left-shift amount applied to the index |
| disp | input | 32 | Displacement operand |
| disp_wide | input | 1 | 1: full 32-bit displacement, 0: sign-extended low byte |
| addr | output | 32 | Computed byte address |
| wb_en | output | 1 | Base writeback strobe, registered |
| wb_val | output | 32 | New base value, registered |

## Verification
Directed vectors put a distinct pattern in every operand at once. A mode that wrongly adds an operand it should ignore, or drops one it should use, therefore produces a visibly different address. Narrow displacements with bit 7 set, and upper bits that should be ignored, separate sign extension from zero extension and from use of the full word. Sums that cross 2^32 exercise wraparound. Each scale code is applied to the same index so the four multipliers can be told apart. Chained update accesses feed each written-back base into the next access, and a randomized stream over all eight mode encodings covers the remaining operand mixes and the reserved encodings.

// File: rtl/eff_addr_gen.sv
module eff_addr_gen #(
  parameter int AW  = 32,
  parameter int NDW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [1:0]    scale,
  input  logic [AW-1:0] disp,
  input  logic          disp_wide,
  output logic [AW-1:0] addr,
  output logic          wb_en,
  output logic [AW-1:0] wb_val
);
  localparam logic [2:0] M_IND = 3'd0;
  localparam logic [2:0] M_BD  = 3'd1;
  localparam logic [2:0] M_RR  = 3'd2;
  localparam logic [2:0] M_SI  = 3'd3;
  localparam logic [2:0] M_SID = 3'd4;
  localparam logic [2:0] M_UPD = 3'd5;

  logic [AW-1:0] dx, sx;

  assign dx = disp_wide ? disp : {{(AW-NDW){disp[NDW-1]}}, disp[NDW-1:0]};
  assign sx = index << scale;

  always_comb begin
    case (mode)
      M_IND:        addr = base;
      M_BD, M_UPD:  addr = base + dx;
      M_RR:         addr = base + index;
      M_SI:         addr = base + sx;
      M_SID:        addr = base + sx + dx;
      default:      addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_en  <= 1'b0;
      wb_val <= '0;
    end else begin
      wb_en <= (mode == M_UPD);
      if (mode == M_UPD) wb_val <= addr;
    end
  end

  // R8
  wb_carries_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_UPD) |=> (wb_en && wb_val == $past(addr)));

  // R9
  wb_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_UPD) |=> (!wb_en && $stable(wb_val)));

  // R1
  indirect_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IND) |-> (addr == base));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > M_UPD) |-> (addr == '0));

  // R12
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SI && scale >= 2'd2 && base[1:0] == 2'b00) |-> (addr[1:0] == 2'b00));
endmodule

// File: tb/tb_eff_addr_gen.sv
module tb_eff_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] base = '0, index = '0, disp = '0;
  logic [1:0]  scale = '0;
  logic        disp_wide = 1'b0;
  logic [31:0] addr, wb_val;
  logic        wb_en;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;
  logic [31:0] last_wb = '0;

  typedef struct {
    logic [31:0] a;
    logic        we;
    logic [31:0] wv;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  eff_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .base(base), .index(index),
    .scale(scale), .disp(disp), .disp_wide(disp_wide),
    .addr(addr), .wb_en(wb_en), .wb_val(wb_val)
  );

  function automatic logic [31:0] model(input logic [2:0] m, input logic [31:0] b,
      input logic [31:0] x, input logic [1:0] s, input logic [31:0] d, input logic w);
    logic [31:0] de, xs;
    de = w ? d : 32'(signed'(d[7:0]));
    xs = x * (32'd1 << s);
    case (m)
      3'd0: return b;
      3'd1: return b + de;
      3'd2: return b + x;
      3'd3: return b + xs;
      3'd4: return b + xs + de;
      3'd5: return b + de;
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input logic [2:0] m, input logic [31:0] b, input logic [31:0] x,
      input logic [1:0] s, input logic [31:0] d, input logic w, input string tag);
    item_t it;
    @(negedge clk);
    mode = m; base = b; index = x; scale = s; disp = d; disp_wide = w;
    it.a = model(m, b, x, s, d, w);
    it.we = (m == 3'd5);
    if (it.we) last_wb = it.a;
    it.wv = last_wb;
    it.tag = tag;
    sb.push_back(it);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      vectors++;
      if (addr !== it.a || wb_en !== it.we || wb_val !== it.wv) begin
        miscompares++;
        $display("FAIL %s: addr=%h wb_en=%b wb_val=%h expected addr=%h wb_en=%b wb_val=%h",
                 it.tag, addr, wb_en, wb_val, it.a, it.we, it.wv);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] chain;
    mode = 3'd5; base = 32'h1234_5678; disp = 32'h10; disp_wide = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (wb_en !== 1'b0 || wb_val !== 32'h0) begin // R11
      miscompares++;
      $display("FAIL R11: wb_en=%b wb_val=%h expected 0/0", wb_en, wb_val);
    end
    @(negedge clk);
    mode = 3'd0;
    rst_n = 1'b1;

    apply(3'd0, 32'hDEAD_BEE0, 32'h1111_1111, 2'd3, 32'h2222_2222, 1'b1, "R1");
    apply(3'd1, 32'h0000_1000, 32'h5555_5555, 2'd1, 32'h0001_0020, 1'b1, "R2");
    apply(3'd1, 32'h0000_1000, 32'h5555_5555, 2'd1, 32'hABCD_EF80, 1'b0, "R3 negative");
    apply(3'd1, 32'h0000_1000, 32'h0,         2'd0, 32'hFFFF_007F, 1'b0, "R3 upper ignored");
    apply(3'd2, 32'h0000_0100, 32'h0000_0034, 2'd3, 32'h7777_0000, 1'b1, "R4");
    for (int s = 0; s < 4; s++)
      apply(3'd3, 32'h0000_2000, 32'h0000_0013, 2'(s), 32'h0000_0999, 1'b1, "R5");
    apply(3'd4, 32'h0000_4000, 32'h0000_0005, 2'd3, 32'h0000_0100, 1'b1, "R6 wide");
    apply(3'd4, 32'h0000_4000, 32'h0000_0005, 2'd2, 32'h0000_00F0, 1'b0, "R6 narrow");
    apply(3'd1, 32'hFFFF_FFF0, 32'h0,         2'd0, 32'h0000_0020, 1'b1, "R7");
    apply(3'd4, 32'hF000_0000, 32'h4000_0000, 2'd2, 32'h0000_0004, 1'b1, "R7 shift out");
    apply(3'd1, 32'h0000_0004, 32'h0,         2'd0, 32'h0000_00F8, 1'b0, "R7 below zero");
    chain = 32'h0000_8000;
    for (int k = 0; k < 4; k++) begin
      apply(3'd5, chain, 32'h9, 2'd1, 32'h0000_0004, 1'b0, "R8");
      chain = chain + 32'd4;
    end
    apply(3'd0, 32'h0000_0042, 32'h0, 2'd0, 32'h0, 1'b1, "R9");
    apply(3'd6, 32'h1234_5678, 32'h1, 2'd1, 32'h8, 1'b1, "R10");
    apply(3'd7, 32'hFFFF_FFFF, 32'h2, 2'd2, 32'h8, 1'b0, "R10");
    for (int i = 0; i < 4; i++)
      apply(3'd3, 32'h0000_3000, 32'(i), 2'd2, 32'h0, 1'b1, "R12");
    for (int n = 0; n < 400; n++)
      apply(3'($urandom), $urandom, $urandom, 2'($urandom), $urandom, 1'($urandom),
            "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 random");
    repeat (3) @(posedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule